// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block derives two banks of divided clocks from a single input clock. Bank A runs at one half or one quarter of the input rate. Bank B runs at one quarter, one fifth or one sixth of the input rate. Each bank drives two identical outputs, and each output has a true signal and a complement signal. Static select inputs choose the ratios. Both banks count from one shared input edge, so their output edges stay phase-related.

An active-high master clear stops both dividers and parks the outputs. An active-low run enable starts and stops the outputs. The enable is retimed inside the block, and it is applied only at a period boundary of each bank. As a result, starting or stopping the outputs never produces a shortened pulse. The divide-by-5 path reaches 50% duty cycle by stretching a rising-edge pulse with a falling-edge retimed copy.

Top module: `cdiv_dual_bank`

## Requirements
- R1: Bank A divides `clk_i` by 2 when `div_sel_a_i` is 0 and by 4 when it is 1.
- R2: Bank B takes its ratio from `div_sel_b_i` as {bit1,bit0}. Code 00 divides by 4, 01 by 6, 10 by 5 and 11 also by 5.
- R3: While `rst_ni` is low or `mr_i` is high, every bit of `qa_o` and `qb_o` is 0 and every complement bit is 1. Raising `mr_i` forces this at once, without waiting for a clock edge.
- R4: On the first rising edge of `clk_i` that samples `mr_i` low, the true outputs of both enabled banks go high together.
- R5: For an even ratio N, each output period is high for exactly N/2 input periods and then low for N/2 input periods.
- R6: At ratio 5, the output is high for 2.5 input periods, from a rising edge of `clk_i` to a falling edge, and then low for 2.5 input periods.
- R7: A select change made while running takes effect at the next period boundary of that bank. Every output period in between has the full length of the old ratio or of the new ratio.
- R8: When `clk_en_ni` goes high, the block captures it on one rising edge and then one falling edge of `clk_i`. Each bank then completes its current period and holds its true outputs low, and no high pulse is shortened. When `clk_en_ni` goes low again, each bank resumes at its next period boundary with a full-width pulse. The dividers keep counting while the outputs are stopped.
- R9: Both outputs of a bank carry identical values at all times.
- R10: Each complement output is the exact inverse of its true output at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mr_i | input | 1 | Master clear, active high |
| clk_en_ni | input | 1 | Output run enable, active low, asynchronous |
| div_sel_a_i | input | 1 | Bank A ratio select |
| div_sel_b_i | input | 2 | Bank B ratio select |
| qa_o | output | NUM_OUT | Bank A true outputs |
| qa_n_o | output | NUM_OUT | Bank A complement outputs |
| qb_o | output | NUM_OUT | Bank B true outputs |
| qb_n_o | output | NUM_OUT | Bank B complement outputs |

## Verification
Raising `mr_i` acts on the outputs within the same half-period. The first pulse after a release appears on the second half-period sample after the release, because only the next rising edge can start it. All widths are counted in half-periods of `clk_i`, with the outputs sampled 1 ns after every clock edge. In these units, ratio N gives a high run of N samples and a low run of N samples. Effects of the enable and of select changes are due within a bounded number of samples: up to three for the enable retiming, plus at most one full old period (2N samples) for the bank to reach its boundary. The checks therefore look at pulse widths and at the last or first high sample inside that window, not at one exact cycle.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int unsigned DIV_MAX = 6;
  localparam int unsigned CNT_W   = $clog2(DIV_MAX + 1);

  typedef logic [CNT_W-1:0] ratio_t;

  localparam ratio_t A_DIV_LO = ratio_t'(2);
  localparam ratio_t A_DIV_HI = ratio_t'(4);
  localparam ratio_t B_DIV_00 = ratio_t'(4);
  localparam ratio_t B_DIV_01 = ratio_t'(6);
  localparam ratio_t B_DIV_1X = ratio_t'(5);
  localparam ratio_t RST_DIV  = ratio_t'(2);

  function automatic ratio_t dec_a(input logic sel);
    return sel ? A_DIV_HI : A_DIV_LO;
  endfunction

  // code 1x is redundant: both map to the odd ratio
  function automatic ratio_t dec_b(input logic [1:0] sel);
    ratio_t r;
    case (sel)
      2'b00:   r = B_DIV_00;
      2'b01:   r = B_DIV_01;
      default: r = B_DIV_1X;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cdiv_en_sync.sv
module cdiv_en_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_ni,
  output logic run_o
);
  logic rise_q, fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rise_q <= 1'b0;
    else         rise_q <= ~en_ni;
  end

  // second stage on the falling edge: one rise and one fall of latency
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= 1'b0;
    else         fall_q <= rise_q;
  end

  assign run_o = fall_q;
endmodule

// File: rtl/cdiv_bank.sv
module cdiv_bank
  import cdiv_pkg::*;
#(
  parameter int unsigned NUM_OUT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mr_i,
  input  logic               run_i,
  input  ratio_t             ratio_i,
  output logic [NUM_OUT-1:0] q_o,
  output logic [NUM_OUT-1:0] q_n_o
);
  ratio_t ratio_q, cnt_q, ratio_nx, cnt_nx;
  logic   at_end, p_q, n_q, gate_q, div_clk;

  assign at_end   = (cnt_q == ratio_q - ratio_t'(1));
  assign ratio_nx = at_end ? ratio_i : ratio_q;
  assign cnt_nx   = at_end ? '0 : cnt_q + ratio_t'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= RST_DIV;
      cnt_q   <= RST_DIV - ratio_t'(1);
      p_q     <= 1'b0;
      gate_q  <= 1'b0;
    end else if (mr_i) begin
      // park on the terminal count so release starts a period on the next edge
      ratio_q <= ratio_i;
      cnt_q   <= ratio_i - ratio_t'(1);
      p_q     <= 1'b0;
      gate_q  <= run_i;
    end else begin
      ratio_q <= ratio_nx;
      cnt_q   <= cnt_nx;
      p_q     <= (cnt_nx < (ratio_nx >> 1));
      if (at_end) gate_q <= run_i;
    end
  end

  // half-period stretch for odd ratios
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   n_q <= 1'b0;
    else if (mr_i) n_q <= 1'b0;
    else           n_q <= p_q & ratio_q[0];
  end

  assign div_clk = (p_q | n_q) & gate_q & ~mr_i;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    assign q_o[i]   = div_clk;
    assign q_n_o[i] = ~div_clk;
  end

  a_r4_release_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mr_i) && !mr_i) |=> (p_q && cnt_q == '0));

  a_r5_rise_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni || mr_i)
    $rose(p_q) |-> (cnt_q == '0));

  a_r6_even_no_stretch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ratio_q[0] |-> !n_q);

  a_r7_ratio_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || mr_i)
    (cnt_q != '0 && !$past(mr_i)) |-> $stable(ratio_q));

  a_r8_gate_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni || mr_i)
    (cnt_q != '0 && !$past(mr_i)) |-> $stable(gate_q));
endmodule

// File: rtl/cdiv_dual_bank.sv
module cdiv_dual_bank
  import cdiv_pkg::*;
#(
  parameter int unsigned NUM_OUT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mr_i,
  input  logic               clk_en_ni,
  input  logic               div_sel_a_i,
  input  logic [1:0]         div_sel_b_i,
  output logic [NUM_OUT-1:0] qa_o,
  output logic [NUM_OUT-1:0] qa_n_o,
  output logic [NUM_OUT-1:0] qb_o,
  output logic [NUM_OUT-1:0] qb_n_o
);
  logic   run;
  ratio_t ratio_a, ratio_b;

  assign ratio_a = dec_a(div_sel_a_i);
  assign ratio_b = dec_b(div_sel_b_i);

  cdiv_en_sync u_en_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_ni  (clk_en_ni),
    .run_o  (run)
  );

  cdiv_bank #(.NUM_OUT(NUM_OUT)) u_bank_a (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mr_i    (mr_i),
    .run_i   (run),
    .ratio_i (ratio_a),
    .q_o     (qa_o),
    .q_n_o   (qa_n_o)
  );

  cdiv_bank #(.NUM_OUT(NUM_OUT)) u_bank_b (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mr_i    (mr_i),
    .run_i   (run),
    .ratio_i (ratio_b),
    .q_o     (qb_o),
    .q_n_o   (qb_n_o)
  );
endmodule

// File: tb/cdiv_dual_bank_test.sv
`timescale 1ns/1ps
module cdiv_dual_bank_test;
  localparam int NO = 2;

  logic clk = 1'b0;
  logic rst_ni, mr, en_n, sel_a;
  logic [1:0] sel_b;
  logic [NO-1:0] qa, qa_n, qb, qb_n;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cdiv_dual_bank #(.NUM_OUT(NO)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .mr_i(mr), .clk_en_ni(en_n),
    .div_sel_a_i(sel_a), .div_sel_b_i(sel_b),
    .qa_o(qa), .qa_n_o(qa_n), .qb_o(qb), .qb_n_o(qb_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(clk);
    #1;
  endtask

  function automatic bit out_of(input int b);
    return (b == 0) ? qa[0] : qb[0];
  endfunction

  // per-bank run-length tracker, units are half periods of clk
  int hi_len[2], lo_len[2], hi_min[2], hi_max[2], hi_last[2];
  int lo_min[2], lo_max[2], rises[2], first_rise[2], last_high[2];
  bit prev[2], seen[2];
  int struct_bad;

  task automatic trk_reset();
    for (int b = 0; b < 2; b++) begin
      hi_len[b] = 0; lo_len[b] = 0; hi_min[b] = 999; hi_max[b] = 0; hi_last[b] = 0;
      lo_min[b] = 999; lo_max[b] = 0; rises[b] = 0; first_rise[b] = -1; last_high[b] = -1;
      prev[b] = out_of(b); seen[b] = 1'b0;
    end
    struct_bad = 0;
  endtask

  task automatic trk_step(input int t);
    for (int b = 0; b < 2; b++) begin
      bit v;
      v = out_of(b);
      if (v && !prev[b]) begin
        rises[b]++;
        if (first_rise[b] < 0) first_rise[b] = t;
        if (seen[b]) begin
          if (lo_len[b] < lo_min[b]) lo_min[b] = lo_len[b];
          if (lo_len[b] > lo_max[b]) lo_max[b] = lo_len[b];
        end
        seen[b] = 1'b1;
        hi_len[b] = 1;
      end else if (v) begin
        hi_len[b]++;
      end else if (prev[b]) begin
        if (seen[b]) begin
          if (hi_len[b] < hi_min[b]) hi_min[b] = hi_len[b];
          if (hi_len[b] > hi_max[b]) hi_max[b] = hi_len[b];
          hi_last[b] = hi_len[b];
        end
        lo_len[b] = 1;
      end else begin
        lo_len[b]++;
      end
      if (v) last_high[b] = t;
      prev[b] = v;
    end
    if (qa[0] != qa[1] || qb[0] != qb[1] || qa_n != ~qa || qb_n != ~qb) struct_bad++;
  endtask

  task automatic restart(input logic a, input logic [1:0] b);
    mr = 1'b1;
    sel_a = a;
    sel_b = b;
    for (int i = 0; i < 6; i++) tick();
    mr = 1'b0;
  endtask

  task automatic t_reset_state();
    rst_ni = 1'b0; mr = 1'b0; en_n = 1'b0; sel_a = 1'b0; sel_b = 2'b00;
    for (int i = 0; i < 5; i++) tick();
    chk(qa == '0 && qb == '0, "R3 true low in reset", int'({qa, qb}), 0);
    chk(qa_n == '1 && qb_n == '1, "R3 R10 complement high in reset", int'({qa_n, qb_n}), 15);
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic t_ratio(input logic a, input logic [1:0] b, input int ea, input int eb,
                         input string req);
    restart(a, b);
    trk_reset();
    for (int t = 0; t < 90; t++) begin tick(); trk_step(t); end
    chk(hi_min[0] == ea && hi_max[0] == ea && lo_min[0] == ea && lo_max[0] == ea,
        {req, " bank A high/low"}, hi_max[0], ea);
    chk(hi_min[1] == eb && hi_max[1] == eb && lo_min[1] == eb && lo_max[1] == eb,
        {req, " bank B high/low"}, hi_max[1], eb);
    chk(struct_bad == 0, "R9 R10 copies and complements", struct_bad, 0);
  endtask

  task automatic t_release_align();
    mr = 1'b1; sel_a = 1'b1; sel_b = 2'b10;
    for (int i = 0; i < 6; i++) tick();
    @(posedge clk); #1;
    mr = 1'b0;
    #0.5;
    chk(qa[0] == 1'b0 && qb[0] == 1'b0, "R4 low right after release", int'({qa[0], qb[0]}), 0);
    tick();
    chk(qa[0] == 1'b0 && qb[0] == 1'b0, "R4 low before first rising edge", int'({qa[0], qb[0]}), 0);
    tick();
    chk(qa[0] == 1'b1 && qb[0] == 1'b1, "R4 both banks rise together", int'({qa[0], qb[0]}), 3);
  endtask

  task automatic t_sel_change();
    restart(1'b0, 2'b00);
    trk_reset();
    for (int t = 0; t < 100; t++) begin
      tick();
      trk_step(t);
      if (t == 9) begin sel_a = 1'b1; sel_b = 2'b10; end
    end
    chk(hi_min[0] == 2 && hi_max[0] == 4 && lo_min[0] == 2 && lo_max[0] == 4,
        "R7 bank A only full old/new periods", hi_min[0], 2);
    chk(hi_last[0] == 4, "R7 bank A settles at new ratio", hi_last[0], 4);
    chk(hi_min[1] == 4 && hi_max[1] == 5 && lo_min[1] == 4 && lo_max[1] == 5,
        "R7 bank B only full old/new periods", hi_min[1], 4);
    chk(hi_last[1] == 5, "R7 bank B settles at new ratio", hi_last[1], 5);
  endtask

  task automatic t_enable();
    restart(1'b1, 2'b10);
    en_n = 1'b0;
    trk_reset();
    for (int t = 0; t < 70; t++) begin
      tick();
      trk_step(t);
      if (t == 7) en_n = 1'b1;
    end
    chk(rises[0] >= 1 && hi_min[0] == 4 && hi_max[0] == 4, "R8 bank A no short pulse on stop",
        hi_min[0], 4);
    chk(rises[1] >= 1 && hi_min[1] == 5 && hi_max[1] == 5, "R8 bank B no short pulse on stop",
        hi_min[1], 5);
    chk(last_high[0] <= 12 + 2 * 4, "R8 bank A stops in time", last_high[0], 20);
    chk(last_high[1] <= 12 + 2 * 5, "R8 bank B stops in time", last_high[1], 22);
    chk(qa_n == '1 && qb_n == '1 && qa == '0 && qb == '0, "R8 R10 parked low while stopped",
        int'({qa, qb}), 0);
    en_n = 1'b0;
    trk_reset();
    for (int t = 0; t < 80; t++) begin tick(); trk_step(t); end
    chk(first_rise[0] >= 0 && first_rise[0] <= 4 + 2 * 4, "R8 bank A resumes in time",
        first_rise[0], 12);
    chk(first_rise[1] >= 0 && first_rise[1] <= 4 + 2 * 5, "R8 bank B resumes in time",
        first_rise[1], 14);
    chk(hi_min[0] == 4 && hi_max[0] == 4 && hi_min[1] == 5 && hi_max[1] == 5,
        "R8 full pulses after resume", hi_min[1], 5);
    chk(struct_bad == 0, "R9 R10 copies and complements on enable", struct_bad, 0);
  endtask

  task automatic t_mr_midrun();
    int guard;
    restart(1'b1, 2'b01);
    guard = 0;
    while (qb[0] != 1'b1 && guard < 100) begin tick(); guard++; end
    chk(qb[0] == 1'b1, "R3 bank B running before clear", int'(qb[0]), 1);
    mr = 1'b1;
    #0.5;
    chk(qa == '0 && qb == '0 && qa_n == '1 && qb_n == '1, "R3 clear forces outputs at once",
        int'({qa, qb}), 0);
    for (int i = 0; i < 8; i++) tick();
    chk(qa == '0 && qb == '0 && qa_n == '1 && qb_n == '1, "R3 outputs held while clear high",
        int'({qa, qb}), 0);
    mr = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_ratio(1'b0, 2'b00, 2, 4, "R1 R2 R5 sel 0/00");
    t_ratio(1'b1, 2'b01, 4, 6, "R1 R2 R5 sel 1/01");
    t_ratio(1'b0, 2'b10, 2, 5, "R2 R6 sel 0/10");
    t_ratio(1'b1, 2'b11, 4, 5, "R2 R6 sel 1/11");
    t_release_align();
    t_sel_change();
    t_enable();
    t_mr_midrun();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule